// File: doc/BRIEF.md
# DMA Channel Descriptor-Chaining Controller

This block keeps the control and status state of a single DMA channel and walks a linked list of command descriptors held in memory. Software programs the channel through a small register write port; storing a nonzero value into the link register makes the channel fetch a descriptor from that address on its own. The descriptor words arrive one per read handshake and overwrite the channel registers. The controller then pulses a start request to an external data mover. When the mover reports completion and the freshly loaded link is nonzero, the next descriptor is fetched and the cycle repeats.

The block also decodes the per-operation transfer size and the addressing mode from the control register. These decoded values go straight to the data mover. Moving data, bus arbitration and burst splitting are outside this block. The mover is seen only through a start/done/error handshake.

Top module: `dma_chain_ctrl`

## Requirements
- R1: A write of a nonzero value to register index 0 (link) while the channel is idle sets the chain-enable and transfer-active status bits and starts a fetch: word k of the descriptor is read at link + 8*k, one word per acknowledged read, and word k is stored into register index k (0 link, 1 source, 2 destination, 3 count, 4..6 auxiliary, 7 control).
- R2: With the simple flag (control bit 5) clear, a descriptor load fetches eight words, and word 7 replaces the control fields.
- R3: With the simple flag set, a descriptor load fetches only words 0..3; registers 4..7 keep their values.
- R4: After a descriptor is loaded, exactly one single-cycle start pulse is issued. On done, a nonzero chain-enable causes the next descriptor to be fetched from the link register; otherwise transfer-active clears and no further start follows.
- R5: Chain-enable follows the zero or nonzero state of each value written to the link register, by software or by a descriptor load, and is forced to 0 whenever master_en is low.
- R6: A mover error clears transfer-active, and no further start follows.
- R7: Control bits 4:2 give the size code. Codes 0..3 decode to 1, 2, 4 and 8 bytes per operation; codes 4..7 decode to 32, 64, 128 and 256 bytes.
- R8: Control bit 0 selects single-address mode (1) or dual-address mode (0). Control bit 1 (memory to I/O) reaches mem_to_io only in single-address mode and reads as 0 on that output in dual-address mode.
- R9: When a descriptor load completes with size code 6 or 7 in dual-address mode, the sticky size-error bit (read bit 11) is set, transfer-active clears, and no start is issued.
- R10: A read error during a descriptor fetch sets the sticky fetch-error bit (read bit 10), clears transfer-active and chain-enable, and ends the chain without a start.
- R11: A control write (index 7) with bit 12 set resets the channel. The control fields, chain-enable, transfer-active and both error bits return to 0, the field values in that same write are discarded, and any fetch in progress is abandoned.
- R12: After reset, every register reads 0, no read request or start is pending, and all status bits are 0.
- R13: A pending read request stays asserted with a stable address until it is acknowledged. Reading index 7 returns the control fields in bits 5:0, chain-enable in bit 8 and transfer-active in bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | Global enable; low forces chain-enable to 0 |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index for write |
| wr_data | input | DATA_W | Write data |
| rd_idx | input | 3 | Register index for read |
| rd_data | output | DATA_W | Read data (combinational) |
| mrd_req | output | 1 | Descriptor read request |
| mrd_addr | output | ADDR_W | Descriptor read address |
| mrd_ack | input | 1 | Read acknowledge, data valid the same cycle |
| mrd_data | input | DATA_W | Read data |
| mrd_err | input | 1 | Read error, valid with acknowledge |
| eng_start | output | 1 | Start pulse to data mover |
| eng_done | input | 1 | Mover completed normally |
| eng_err | input | 1 | Mover stopped on error |
| chain_en | output | 1 | Chain-enable status |
| xfer_active | output | 1 | Transfer-active status |
| fetch_err | output | 1 | Sticky descriptor read error |
| size_err | output | 1 | Sticky illegal size/mode error |
| bytes_per_op | output | 9 | Decoded bytes per operation |
| single_mode | output | 1 | Single-address mode selected |
| mem_to_io | output | 1 | Effective direction, 0 in dual mode |
| size_illegal | output | 1 | Current size code not allowed in current mode |

## Verification
The assertions check cycle-local rules on every cycle: the read request holds its address until acknowledged, the start pulse lasts one cycle and never comes while the size setting is illegal or the channel is inactive, master_en low clears chain-enable, a fetch error lands in the status at the next edge, and a channel reset clears all status. Multi-step behaviour can only be shown by the bench's scenarios. This covers the descriptor address sequence, which registers a full or simple load overwrites, following a chain across two descriptors, stopping after a zero link, a software zero write, an engine error, and the decode table.

// File: rtl/dmac_pkg.sv
// Shared definitions for the DMA chaining channel: register indices,
// control/status bit positions, control field struct and sequencer states.
package dmac_pkg;
    localparam int unsigned NUM_CH_REGS = 8;
    localparam int unsigned SIMPLE_WORDS = 4;
    localparam int unsigned IDX_W = $clog2(NUM_CH_REGS);
    localparam int unsigned REG_LINK = 0;
    localparam int unsigned REG_CTRL = NUM_CH_REGS - 1;
    localparam int unsigned CTRL_FIELD_W = 6;
    localparam int unsigned BIT_CHAIN_EN = 8;
    localparam int unsigned BIT_ACTIVE = 9;
    localparam int unsigned BIT_FETCH_ERR = 10;
    localparam int unsigned BIT_SIZE_ERR = 11;
    localparam int unsigned BIT_CH_RESET = 12;

    typedef struct packed {
        logic       simple;
        logic [2:0] size;
        logic       m2io;
        logic       single;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_START,
        ST_BUSY
    } ch_state_t;
endpackage

// File: rtl/dmac_size_decode.sv
// Decodes the size code and addressing mode of the control register.
// Assumes: pure combinational; the caller registers nothing here.
module dmac_size_decode #(
    parameter int unsigned BYTES_W = 9
) (
    input  logic [2:0]         size_code,
    input  logic               single,
    input  logic               m2io,
    output logic [BYTES_W-1:0] bytes_per_op,
    output logic               single_mode,
    output logic               mem_to_io,
    output logic               size_illegal
);
    localparam logic [BYTES_W-1:0] ONE_BYTE = BYTES_W'(1);
    localparam logic [BYTES_W-1:0] BLOCK_BASE = BYTES_W'(32);

    // Byte count: small codes are powers of two, large codes are double-word blocks.
    always_comb begin
        if (size_code[2]) bytes_per_op = BLOCK_BASE << size_code[1:0];
        else              bytes_per_op = ONE_BYTE << size_code[1:0];
    end

    // Mode outputs: direction only meaningful in single-address mode.
    always_comb begin
        single_mode  = single;
        mem_to_io    = single & m2io;
        size_illegal = size_code[2] & size_code[1] & ~single;
    end
endmodule

// File: rtl/dmac_desc_fetch.sv
// Fetches one command descriptor, one word per read handshake, at
// consecutive STRIDE-byte addresses. Emits a load strobe per word.
// Assumes: ack and data/err are valid in the same cycle as the request.
module dmac_desc_fetch #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STRIDE = 8,
    parameter int unsigned NREGS = 8,
    parameter int unsigned SIMPLE_N = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     kick,
    input  logic                     abort,
    input  logic [ADDR_W-1:0]        base,
    input  logic                     simple,
    output logic                     mrd_req,
    output logic [ADDR_W-1:0]        mrd_addr,
    input  logic                     mrd_ack,
    input  logic [DATA_W-1:0]        mrd_data,
    input  logic                     mrd_err,
    output logic                     ld_valid,
    output logic [$clog2(NREGS)-1:0] ld_idx,
    output logic [DATA_W-1:0]        ld_data,
    output logic                     last,
    output logic                     rd_err
);
    localparam int unsigned IW = $clog2(NREGS);
    localparam logic [IW-1:0] LAST_FULL = IW'(NREGS - 1);
    localparam logic [IW-1:0] LAST_SIMPLE = IW'(SIMPLE_N - 1);
    localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(STRIDE);

    logic              busy_q;
    logic [IW-1:0]     word_q;
    logic [ADDR_W-1:0] base_q;

    // Request and per-word strobes derived from the current word.
    always_comb begin
        mrd_req  = busy_q;
        mrd_addr = base_q + (ADDR_W'(word_q) * STRIDE_A);
        ld_valid = busy_q & mrd_ack & ~mrd_err;
        rd_err   = busy_q & mrd_ack & mrd_err;
        ld_idx   = word_q;
        ld_data  = mrd_data;
        last     = ld_valid & (word_q == (simple ? LAST_SIMPLE : LAST_FULL));
    end

    // Word counter and base capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            word_q <= '0;
            base_q <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (kick) begin
            busy_q <= 1'b1;
            word_q <= '0;
            base_q <= base;
        end else if (busy_q && mrd_ack) begin
            if (mrd_err || last) busy_q <= 1'b0;
            else                 word_q <= word_q + 1'b1;
        end
    end
endmodule

// File: rtl/dma_chain_ctrl.sv
// One DMA channel: register file, descriptor chaining sequencer and
// size/mode decode. The data mover is reached by start/done/error only.
// Assumes: single clock, synchronous active-low reset, done/err only while busy.
module dma_chain_ctrl
    import dmac_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DESC_STRIDE = 8,
    parameter int unsigned BYTES_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               master_en,
    input  logic               wr_en,
    input  logic [2:0]         wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [2:0]         rd_idx,
    output logic [DATA_W-1:0]  rd_data,
    output logic               mrd_req,
    output logic [ADDR_W-1:0]  mrd_addr,
    input  logic               mrd_ack,
    input  logic [DATA_W-1:0]  mrd_data,
    input  logic               mrd_err,
    output logic               eng_start,
    input  logic               eng_done,
    input  logic               eng_err,
    output logic               chain_en,
    output logic               xfer_active,
    output logic               fetch_err,
    output logic               size_err,
    output logic [BYTES_W-1:0] bytes_per_op,
    output logic               single_mode,
    output logic               mem_to_io,
    output logic               size_illegal
);
    localparam int unsigned NDATA = NUM_CH_REGS - 1;
    localparam int unsigned IW = IDX_W;

    logic [DATA_W-1:0] regs_q [NDATA];
    ctrl_t             ctrl_q;
    ch_state_t         state_q;
    logic              chain_en_q, active_q, fetch_err_q, size_err_q;

    logic              ch_rst, link_wr, link_nz, kick;
    logic [ADDR_W-1:0] kick_base;
    logic              ld_valid, ld_last, ld_rderr;
    logic [IW-1:0]     ld_idx;
    logic [DATA_W-1:0] ld_data;

    // Decode software write intents.
    always_comb begin
        ch_rst  = wr_en && (wr_idx == IW'(REG_CTRL)) && wr_data[BIT_CH_RESET];
        link_wr = wr_en && (wr_idx == IW'(REG_LINK));
        link_nz = (wr_data != '0);
    end

    // Fetch trigger: a software link write when idle, or a chain step after done.
    always_comb begin
        kick = !ch_rst &&
               (((state_q == ST_IDLE) && link_wr && link_nz) ||
                ((state_q == ST_BUSY) && !eng_err && eng_done && chain_en_q));
        kick_base = (state_q == ST_IDLE) ? ADDR_W'(wr_data) : ADDR_W'(regs_q[REG_LINK]);
    end

    dmac_desc_fetch #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .STRIDE  (DESC_STRIDE),
        .NREGS   (NUM_CH_REGS),
        .SIMPLE_N(SIMPLE_WORDS)
    ) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (kick),
        .abort   (ch_rst),
        .base    (kick_base),
        .simple  (ctrl_q.simple),
        .mrd_req (mrd_req),
        .mrd_addr(mrd_addr),
        .mrd_ack (mrd_ack),
        .mrd_data(mrd_data),
        .mrd_err (mrd_err),
        .ld_valid(ld_valid),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .last    (ld_last),
        .rd_err  (ld_rderr)
    );

    dmac_size_decode #(.BYTES_W(BYTES_W)) u_decode (
        .size_code   (ctrl_q.size),
        .single      (ctrl_q.single),
        .m2io        (ctrl_q.m2io),
        .bytes_per_op(bytes_per_op),
        .single_mode (single_mode),
        .mem_to_io   (mem_to_io),
        .size_illegal(size_illegal)
    );

    // Data registers 0..6: a descriptor word wins over a software write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NDATA; i++) begin
            if (!rst_n)                                 regs_q[i] <= '0;
            else if (ld_valid && ld_idx == IW'(i))      regs_q[i] <= ld_data;
            else if (wr_en && wr_idx == IW'(i))         regs_q[i] <= wr_data;
        end
    end

    // Control fields: channel reset first, then descriptor word 7, then software.
    always_ff @(posedge clk) begin
        if (!rst_n || ch_rst)                            ctrl_q <= '0;
        else if (ld_valid && ld_idx == IW'(REG_CTRL))    ctrl_q <= ctrl_t'(ld_data[CTRL_FIELD_W-1:0]);
        else if (wr_en && wr_idx == IW'(REG_CTRL))       ctrl_q <= ctrl_t'(wr_data[CTRL_FIELD_W-1:0]);
    end

    // Chain-enable follows every link write; master disable and resets dominate.
    always_ff @(posedge clk) begin
        if (!rst_n || ch_rst || !master_en)              chain_en_q <= 1'b0;
        else if (ld_valid && ld_idx == IW'(REG_LINK))    chain_en_q <= (ld_data != '0);
        else if (link_wr)                                chain_en_q <= link_nz;
        else if (ld_rderr)                               chain_en_q <= 1'b0;
    end

    // Sequencer with active and sticky error status.
    always_ff @(posedge clk) begin
        if (!rst_n || ch_rst) begin
            state_q     <= ST_IDLE;
            active_q    <= 1'b0;
            fetch_err_q <= 1'b0;
            size_err_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (kick) begin
                        active_q <= 1'b1;
                        state_q  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (ld_rderr) begin
                        fetch_err_q <= 1'b1;
                        active_q    <= 1'b0;
                        state_q     <= ST_IDLE;
                    end else if (ld_last) begin
                        state_q <= ST_START;
                    end
                end
                ST_START: begin
                    if (size_illegal) begin
                        size_err_q <= 1'b1;
                        active_q   <= 1'b0;
                        state_q    <= ST_IDLE;
                    end else begin
                        state_q <= ST_BUSY;
                    end
                end
                default: begin
                    if (eng_err) begin
                        active_q <= 1'b0;
                        state_q  <= ST_IDLE;
                    end else if (eng_done) begin
                        if (kick) begin
                            state_q <= ST_FETCH;
                        end else begin
                            active_q <= 1'b0;
                            state_q  <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // Start pulse for the mover when a legal descriptor has been loaded.
    always_comb eng_start = (state_q == ST_START) && !size_illegal && !ch_rst;

    // Read mux: data registers, or control fields plus status.
    always_comb begin
        rd_data = '0;
        if (rd_idx == IW'(REG_CTRL)) begin
            rd_data[CTRL_FIELD_W-1:0] = ctrl_q;
            rd_data[BIT_CHAIN_EN]     = chain_en_q;
            rd_data[BIT_ACTIVE]       = active_q;
            rd_data[BIT_FETCH_ERR]    = fetch_err_q;
            rd_data[BIT_SIZE_ERR]     = size_err_q;
        end else begin
            for (int i = 0; i < NDATA; i++)
                if (rd_idx == IW'(i)) rd_data = regs_q[i];
        end
    end

    // Status ports.
    always_comb begin
        chain_en    = chain_en_q;
        xfer_active = active_q;
        fetch_err   = fetch_err_q;
        size_err    = size_err_q;
    end
endmodule

// File: rtl/dma_chain_ctrl_chk.sv
// Protocol and status checker for dma_chain_ctrl, attached by bind.
// Assumes: sees only top-level ports; the channel reset bit is passed in.
module dma_chain_ctrl_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_en,
    input logic              wr_en,
    input logic [2:0]        wr_idx,
    input logic              ch_rst_bit,
    input logic              mrd_req,
    input logic [ADDR_W-1:0] mrd_addr,
    input logic              mrd_ack,
    input logic              mrd_err,
    input logic              eng_start,
    input logic              chain_en,
    input logic              xfer_active,
    input logic              fetch_err,
    input logic              size_err,
    input logic              size_illegal
);
    logic rst_wr, link_wr;
    // Channel reset and link write seen at the ports.
    always_comb begin
        rst_wr  = wr_en && (wr_idx == 3'd7) && ch_rst_bit;
        link_wr = wr_en && (wr_idx == 3'd0);
    end

    assert_req_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req && !mrd_ack && !rst_wr) |=> (mrd_req && $stable(mrd_addr)));

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (xfer_active && !size_illegal));

    assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_no_illegal_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        size_illegal |-> !eng_start);

    assert_master_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !chain_en);

    assert_fetch_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req && mrd_ack && mrd_err && !rst_wr && !link_wr) |=>
        (!xfer_active && fetch_err && !chain_en));

    assert_chan_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr |=> (!chain_en && !xfer_active && !fetch_err && !size_err && !mrd_req));
endmodule

bind dma_chain_ctrl dma_chain_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_en   (master_en),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .ch_rst_bit  (wr_data[dmac_pkg::BIT_CH_RESET]),
    .mrd_req     (mrd_req),
    .mrd_addr    (mrd_addr),
    .mrd_ack     (mrd_ack),
    .mrd_err     (mrd_err),
    .eng_start   (eng_start),
    .chain_en    (chain_en),
    .xfer_active (xfer_active),
    .fetch_err   (fetch_err),
    .size_err    (size_err),
    .size_illegal(size_illegal)
);

// File: tb/dma_chain_ctrl_test.sv
module dma_chain_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        mrd_req, mrd_ack, mrd_err;
    logic [31:0] mrd_addr, mrd_data;
    logic        eng_start, eng_done, eng_err;
    logic        chain_en, xfer_active, fetch_err, size_err;
    logic [8:0]  bytes_per_op;
    logic        single_mode, mem_to_io, size_illegal;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [31:0] mem [0:255];
    logic [31:0] err_addr = 32'hFFFF_FFF8;
    logic        ack_en = 1'b1;
    int          eng_delay = 4;
    logic        eng_err_mode = 1'b0;
    int          eng_cnt;
    int          starts;
    int          nreads;
    logic [31:0] rlog [0:63];

    always #10 clk = ~clk;

    dma_chain_ctrl uut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack),
        .mrd_data(mrd_data), .mrd_err(mrd_err),
        .eng_start(eng_start), .eng_done(eng_done), .eng_err(eng_err),
        .chain_en(chain_en), .xfer_active(xfer_active),
        .fetch_err(fetch_err), .size_err(size_err),
        .bytes_per_op(bytes_per_op), .single_mode(single_mode),
        .mem_to_io(mem_to_io), .size_illegal(size_illegal)
    );

    // Memory model: zero-wait acknowledge, error on one chosen address.
    always_comb begin
        mrd_ack  = mrd_req && ack_en;
        mrd_data = mem[mrd_addr[10:3]];
        mrd_err  = mrd_req && ack_en && (mrd_addr == err_addr);
    end

    // Mover model and read logger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_cnt <= 0;
            starts  <= 0;
            nreads  <= 0;
        end else begin
            if (eng_start) begin
                eng_cnt <= eng_delay;
                starts  <= starts + 1;
            end else if (eng_cnt != 0) begin
                eng_cnt <= eng_cnt - 1;
            end
            if (mrd_req && mrd_ack) begin
                if (nreads < 64) rlog[nreads] <= mrd_addr;
                nreads <= nreads + 1;
            end
        end
    end
    assign eng_done = (eng_cnt == 1) && !eng_err_mode;
    assign eng_err  = (eng_cnt == 1) && eng_err_mode;

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            report();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [2:0] idx, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        rd_idx = idx;
        #1;
        d = rd_data;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            if (!xfer_active) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_starts(input int n);
        for (int i = 0; i < 400; i++) begin
            if (starts >= n) break;
            @(negedge clk);
        end
    endtask

    // Decode table: {ctrl[5:0], bytes[8:0], single, mem_to_io, illegal}
    localparam logic [17:0] DEC_VEC [10] = '{
        {6'h02, 9'd1,   3'b000},
        {6'h06, 9'd2,   3'b000},
        {6'h0A, 9'd4,   3'b000},
        {6'h0E, 9'd8,   3'b000},
        {6'h12, 9'd32,  3'b000},
        {6'h16, 9'd64,  3'b000},
        {6'h1A, 9'd128, 3'b001},
        {6'h1E, 9'd256, 3'b001},
        {6'h1B, 9'd128, 3'b110},
        {6'h1D, 9'd256, 3'b100}
    };

    initial begin
        logic [31:0] v;
        int s0, n0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        // Descriptor A at 0x100, full load, links to 0x200.
        mem[8'h20] = 32'h200;  mem[8'h21] = 32'h1000; mem[8'h22] = 32'h2000;
        mem[8'h23] = 32'h10;   mem[8'h24] = 32'h44;   mem[8'h25] = 32'h55;
        mem[8'h26] = 32'h66;   mem[8'h27] = 32'h01;
        // Descriptor B at 0x200, end of chain.
        mem[8'h41] = 32'h3000; mem[8'h42] = 32'h4000; mem[8'h43] = 32'h20;
        mem[8'h44] = 32'h77;   mem[8'h45] = 32'h88;   mem[8'h46] = 32'h99;
        // Descriptor C at 0x300, end of chain, full-load tail would change ctrl.
        mem[8'h61] = 32'h5;    mem[8'h62] = 32'h6;    mem[8'h63] = 32'h7;
        mem[8'h64] = 32'h11;   mem[8'h65] = 32'h22;   mem[8'h66] = 32'h33;
        mem[8'h67] = 32'h3F;
        // Descriptor D at 0x380 links to C.
        mem[8'h70] = 32'h300;  mem[8'h71] = 32'h9;
        // Descriptor E at 0x500, end of chain.
        mem[8'hA1] = 32'h1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        rd(3'd7, v); chk("R12 ctrl/status after reset", v, 32'h0);
        rd(3'd0, v); chk("R12 link after reset", v, 32'h0);
        chk("R12 no request", {31'b0, mrd_req}, 32'h0);
        chk("R12 no start", {31'b0, eng_start}, 32'h0);

        // R7/R8: decode table walk
        for (int k = 0; k < 10; k++) begin
            cpu_wr(3'd7, {26'b0, DEC_VEC[k][17:12]});
            chk("R7 bytes per op", {23'b0, bytes_per_op}, {23'b0, DEC_VEC[k][11:3]});
            chk("R8 single/mem_to_io/illegal",
                {29'b0, single_mode, mem_to_io, size_illegal}, {29'b0, DEC_VEC[k][2:0]});
        end

        // R1/R2/R4: two-descriptor chain with full loads
        cpu_wr(3'd7, 32'h0);
        s0 = starts; n0 = nreads;
        cpu_wr(3'd0, 32'h100);
        chk("R1 active after link write", {30'b0, chain_en, xfer_active}, 32'h3);
        wait_idle();
        chk("R1 first read address", rlog[n0], 32'h100);
        chk("R1 fourth read address", rlog[n0 + 3], 32'h118);
        chk("R4 second descriptor base", rlog[n0 + 8], 32'h200);
        chk("R2 full loads read 16 words", nreads - n0, 16);
        chk("R4 two starts for two descriptors", starts - s0, 2);
        rd(3'd1, v); chk("R4 source from second descriptor", v, 32'h3000);
        rd(3'd3, v); chk("R1 count register", v, 32'h20);
        rd(3'd4, v); chk("R2 aux register loaded", v, 32'h77);
        rd(3'd7, v); chk("R2 ctrl replaced, chain done", v, 32'h0);

        // R3: simple load keeps registers 4..7
        cpu_wr(3'd7, 32'h20);
        cpu_wr(3'd4, 32'hAAAA);
        s0 = starts; n0 = nreads;
        cpu_wr(3'd0, 32'h300);
        wait_idle();
        chk("R3 four words read", nreads - n0, 4);
        rd(3'd4, v); chk("R3 aux register kept", v, 32'hAAAA);
        rd(3'd7, v); chk("R3 ctrl kept", v, 32'h20);
        rd(3'd1, v); chk("R3 source loaded", v, 32'h5);
        chk("R4 one start", starts - s0, 1);

        // R5: software zero write stops the chain
        eng_delay = 30;
        s0 = starts;
        cpu_wr(3'd0, 32'h380);
        wait_starts(s0 + 1);
        cpu_wr(3'd0, 32'h0);
        chk("R5 chain_en cleared by zero write", {31'b0, chain_en}, 32'h0);
        wait_idle();
        repeat (5) @(negedge clk);
        chk("R5 no further start after zero write", starts - s0, 1);

        // R5: master disable clears chain-enable
        s0 = starts;
        cpu_wr(3'd0, 32'h380);
        chk("R5 chain_en set by link write", {31'b0, chain_en}, 32'h1);
        wait_starts(s0 + 1);
        master_en = 1'b0;
        @(negedge clk);
        chk("R5 chain_en cleared by master disable", {31'b0, chain_en}, 32'h0);
        master_en = 1'b1;
        wait_idle();
        repeat (5) @(negedge clk);
        chk("R5 no further start after master disable", starts - s0, 1);

        // R6: mover error ends the chain
        eng_delay = 4;
        eng_err_mode = 1'b1;
        s0 = starts;
        cpu_wr(3'd0, 32'h380);
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R6 inactive after mover error", {31'b0, xfer_active}, 32'h0);
        chk("R6 no further start after error", starts - s0, 1);
        eng_err_mode = 1'b0;

        // R10: read error on word 1
        err_addr = 32'h408;
        s0 = starts;
        cpu_wr(3'd0, 32'h400);
        wait_idle();
        rd(3'd7, v);
        chk("R10 status after read error", v & 32'h0F00, 32'h0400);
        chk("R10 no start", starts - s0, 0);
        err_addr = 32'hFFFF_FFF8;

        // R9: illegal size in dual mode
        cpu_wr(3'd7, 32'h38);
        s0 = starts;
        cpu_wr(3'd0, 32'h500);
        wait_idle();
        chk("R9 size error set", {31'b0, size_err}, 32'h1);
        chk("R9 no start", starts - s0, 0);
        rd(3'd7, v); chk("R9 sticky bit and fetch error kept", v & 32'h0E00, 32'h0C00);

        // R11: channel reset discards simultaneous fields
        cpu_wr(3'd7, 32'h103F);
        rd(3'd7, v); chk("R11 ctrl/status cleared", v, 32'h0);

        // R13/R11: stalled fetch holds address, then reset abandons it
        ack_en = 1'b0;
        cpu_wr(3'd0, 32'h100);
        repeat (3) @(negedge clk);
        chk("R13 request held while stalled", {31'b0, mrd_req}, 32'h1);
        chk("R13 address stable while stalled", mrd_addr, 32'h100);
        rd(3'd7, v); chk("R13 status bits while fetching", v & 32'h0300, 32'h0300);
        cpu_wr(3'd7, 32'h1000);
        chk("R11 fetch abandoned", {30'b0, mrd_req, xfer_active}, 32'h0);
        ack_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 stays idle", {30'b0, mrd_req, xfer_active}, 32'h0);

        report();
    end
endmodule